// File: doc/BRIEF.md
# Battery Backup and Test Sequencer

This block is the digital controller that sits behind a supply supervisor's comparators. It decides whether the protected output rail is fed from the main supply or from a backup battery. It also schedules periodic load tests of that battery and keeps a latched health flag. Its inputs are comparator flags, already resolved to logic levels, plus a slow timebase tick. All of its durations are counted in ticks of that timebase.

The output moves to the battery only when the main supply is under its reset threshold and also under the battery voltage. It moves back once the supply clears the battery voltage by the hysteresis margin. Each move passes through a break-before-make gap in which neither switch is selected. The gap ends on the next tick.

A seal latch keeps the battery off the rail until the main supply has come up once. A re-seal request, taken only while the supply is flagged off, clears the latch again. Each time the rail returns to the main supply, the block runs a battery test window. Further windows follow at a fixed period. The comparator result is captured at the end of each completed window.

Top module: `bkup_seq`

## Requirements
- R1: After reset, main_sel_o, bat_sel_o, bat_on_o, bat_ok_o and test_load_o are 0 and test_pulse_o is at its idle level (0 when TEST_PULSE_LOW=0). The first clock edge that sees vmain_low_i=0 selects the main supply on that edge.
- R2: The rail leaves the main supply only on an edge where vmain_low_i=1 and vmain_lt_bat_i=1. If either flag is 0 on the tick that ends the gap, the rail returns to the main supply instead of the battery.
- R3: From the battery, an edge with vmain_gt_bat_hys_i=1 starts the gap back to the main supply. While that flag is 0, the battery stays selected, whatever vmain_low_i says.
- R4: main_sel_o and bat_sel_o are never both 1. Every switchover holds both at 0 from the edge that starts it until the first edge with tick_i=1 that follows.
- R5: bat_on_o equals bat_sel_o at all times.
- R6: The battery is never selected unless the main supply has been seen above its reset threshold since reset or since the last re-seal. A re-seal (reseal_i=1 and vmain_off_i=1 on one edge) deselects both switches at once. reseal_i has no effect while vmain_off_i=0.
- R7: Every edge that selects the main supply starts a test. test_load_o is then 1 for exactly TEST_TICKS ticks, counted after that edge.
- R8: test_pulse_o is active from the start of each test for PULSE_TICKS ticks (active level 1 when TEST_PULSE_LOW=0, 0 otherwise).
- R9: While the main supply stays selected, a new test starts every PERIOD_TICKS ticks, measured from the start of the previous one.
- R10: The test result is bat_good_i sampled on the tick that ends a test window. It is held until the next completed window, and a window cut short is not sampled. bat_ok_o shows the held result (reset value 0) while the main supply is selected.
- R11: Whenever the main supply is not selected (battery, gap or idle), test_load_o is 0, the pulse is idle and bat_ok_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| vmain_low_i | input | 1 | Main supply below reset threshold |
| vmain_lt_bat_i | input | 1 | Main supply below battery voltage |
| vmain_gt_bat_hys_i | input | 1 | Main supply above battery voltage plus hysteresis |
| bat_good_i | input | 1 | Battery above minimum healthy voltage |
| reseal_i | input | 1 | Request to re-seal the battery |
| vmain_off_i | input | 1 | Main supply is off; qualifies reseal_i |
| main_sel_o | output | 1 | Connect main supply to the rail |
| bat_sel_o | output | 1 | Connect battery to the rail |
| bat_on_o | output | 1 | Backup mode indicator |
| bat_ok_o | output | 1 | Latched battery health result |
| test_load_o | output | 1 | Battery test load enable |
| test_pulse_o | output | 1 | Battery test pulse, polarity set by parameter |

## Verification
A wrong path state shows up on the switch selects at the very next edge after a supply-flag change. A stale or stuck gap shows as both selects low past the first tick. A wrong scheduler count shows as test_load_o or the pulse dropping one tick early or late, or as a retest missing at the tick where the period expires. A result latched at the wrong time, or sampled from a window that was cut short, shows only on bat_ok_o. It is visible from the window's end, or from the next return to the main supply. The bench therefore checks held values across backup excursions and cut-short windows, not only at the moment a window ends.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

   typedef enum logic [2:0] {
      PS_IDLE    = 3'd0,
      PS_MAIN    = 3'd1,
      PS_TO_BAT  = 3'd2,
      PS_BAT     = 3'd3,
      PS_TO_MAIN = 3'd4
   } pwr_st_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/bkup_seal.sv
module bkup_seal (
   input  logic clk,
   input  logic rst_n,
   input  logic vmain_low,
   input  logic reseal_req,
   input  logic vmain_off,
   output logic armed,
   output logic reseal_hit
);

   assign reseal_hit = reseal_req & vmain_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed <= 1'b0;
      else if (reseal_hit) armed <= 1'b0;
      else if (!vmain_low) armed <= 1'b1;
   end

   // R6: the latch only arms after the supply was seen above threshold
   assert_arm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(!vmain_low));

endmodule

// File: rtl/bkup_path.sv
module bkup_path
   import bkup_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    vmain_low,
   input  logic    vmain_lt_bat,
   input  logic    vmain_gt_bat_hys,
   input  logic    armed,
   input  logic    reseal_hit,
   output pwr_st_t st_nxt,
   output logic    main_sel,
   output logic    bat_sel
);

   pwr_st_t st_q;
   logic    want_bat;

   assign want_bat = armed & vmain_low & vmain_lt_bat;

   always_comb begin
      st_nxt = st_q;
      if (reseal_hit) begin
         st_nxt = PS_IDLE;
      end else begin
         case (st_q)
            PS_IDLE:    if (!vmain_low) st_nxt = PS_MAIN;
            PS_MAIN:    if (want_bat) st_nxt = PS_TO_BAT;
            PS_TO_BAT:  if (tick) st_nxt = want_bat ? PS_BAT : PS_MAIN;
            PS_BAT:     if (vmain_gt_bat_hys) st_nxt = PS_TO_MAIN;
            PS_TO_MAIN: if (tick) st_nxt = vmain_gt_bat_hys ? PS_MAIN
                                          : (armed ? PS_BAT : PS_IDLE);
            default:    st_nxt = PS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         main_sel <= 1'b0;
         bat_sel  <= 1'b0;
      end else begin
         st_q     <= st_nxt;
         main_sel <= (st_nxt == PS_MAIN);
         bat_sel  <= (st_nxt == PS_BAT);
      end
   end

   // R4: break-before-make in both directions
   assert_bbm_to_bat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bat_sel) |-> $past(!main_sel));
   assert_bbm_to_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_sel) |-> $past(!bat_sel));
   // R2: battery selected only after both low-supply flags held
   assert_bat_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bat_sel) |-> $past(vmain_low && vmain_lt_bat));
   // R4: a gap ends only on a tick
   assert_gap_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!main_sel && !bat_sel && st_q != PS_IDLE) && (main_sel || bat_sel)
       && !$past(reseal_hit)) |-> $past(tick));

endmodule

// File: rtl/bkup_sched.sv
module bkup_sched
   import bkup_pkg::*;
#(
   parameter int unsigned TEST_TICKS   = 1235,
   parameter int unsigned PULSE_TICKS  = 1300,
   parameter int unsigned PERIOD_TICKS = 86_400_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic on_main_nxt,
   input  logic main_entry,
   input  logic bat_good,
   output logic test_on,
   output logic pulse_on,
   output logic bat_res
);

   localparam int unsigned WIN_W = cnt_width(TEST_TICKS);
   localparam int unsigned PLS_W = cnt_width(PULSE_TICKS);
   localparam int unsigned PER_W = cnt_width(PERIOD_TICKS);
   localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(TEST_TICKS);
   localparam logic [PLS_W-1:0] PLS_LOAD = PLS_W'(PULSE_TICKS);
   localparam logic [PER_W-1:0] PER_LOAD = PER_W'(PERIOD_TICKS);
   localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);
   localparam logic [PLS_W-1:0] PLS_ONE  = PLS_W'(1);
   localparam logic [PER_W-1:0] PER_ONE  = PER_W'(1);

   logic [WIN_W-1:0] win_left;
   logic [PLS_W-1:0] pls_left;
   logic [PER_W-1:0] per_left;
   logic             start;

   assign start = main_entry | (tick & (per_left == PER_ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_on  <= 1'b0;
         pulse_on <= 1'b0;
         bat_res  <= 1'b0;
         win_left <= '0;
         pls_left <= '0;
         per_left <= '0;
      end else if (!on_main_nxt) begin
         test_on  <= 1'b0;
         pulse_on <= 1'b0;
      end else if (start) begin
         test_on  <= 1'b1;
         pulse_on <= 1'b1;
         win_left <= WIN_LOAD;
         pls_left <= PLS_LOAD;
         per_left <= PER_LOAD;
      end else if (tick) begin
         per_left <= per_left - PER_ONE;
         if (test_on) begin
            if (win_left == WIN_ONE) begin
               test_on <= 1'b0;
               bat_res <= bat_good;
            end else begin
               win_left <= win_left - WIN_ONE;
            end
         end
         if (pulse_on) begin
            if (pls_left == PLS_ONE) pulse_on <= 1'b0;
            else                     pls_left <= pls_left - PLS_ONE;
         end
      end
   end

   // R10: the result changes only as a window closes normally
   assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bat_res != $past(bat_res)) |-> ($fell(test_on) && $past(tick)));
   // R7: a window never opens without a start request
   assert_win_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_on) |-> $past(on_main_nxt));

endmodule

// File: rtl/bkup_seq.sv
module bkup_seq
   import bkup_pkg::*;
#(
   parameter int unsigned TEST_TICKS     = 1235,
   parameter int unsigned PULSE_TICKS    = 1300,
   parameter int unsigned PERIOD_TICKS   = 86_400_000,
   parameter bit          TEST_PULSE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic vmain_low_i,
   input  logic vmain_lt_bat_i,
   input  logic vmain_gt_bat_hys_i,
   input  logic bat_good_i,
   input  logic reseal_i,
   input  logic vmain_off_i,
   output logic main_sel_o,
   output logic bat_sel_o,
   output logic bat_on_o,
   output logic bat_ok_o,
   output logic test_load_o,
   output logic test_pulse_o
);

   if (TEST_TICKS < 1) begin : g_bad_test
      $error("TEST_TICKS must be at least 1");
   end
   if (PULSE_TICKS < 1) begin : g_bad_pulse
      $error("PULSE_TICKS must be at least 1");
   end
   if (PERIOD_TICKS <= TEST_TICKS || PERIOD_TICKS <= PULSE_TICKS) begin : g_bad_period
      $error("PERIOD_TICKS must exceed both the window and the pulse");
   end

   logic    armed;
   logic    reseal_hit;
   pwr_st_t st_nxt;
   logic    main_sel;
   logic    bat_sel;
   logic    on_main_nxt;
   logic    main_entry;
   logic    test_on;
   logic    pulse_on;
   logic    bat_res;

   bkup_seal u_seal (
      .clk        (clk),
      .rst_n      (rst_n),
      .vmain_low  (vmain_low_i),
      .reseal_req (reseal_i),
      .vmain_off  (vmain_off_i),
      .armed      (armed),
      .reseal_hit (reseal_hit)
   );

   bkup_path u_path (
      .clk              (clk),
      .rst_n            (rst_n),
      .tick             (tick_i),
      .vmain_low        (vmain_low_i),
      .vmain_lt_bat     (vmain_lt_bat_i),
      .vmain_gt_bat_hys (vmain_gt_bat_hys_i),
      .armed            (armed),
      .reseal_hit       (reseal_hit),
      .st_nxt           (st_nxt),
      .main_sel         (main_sel),
      .bat_sel          (bat_sel)
   );

   assign on_main_nxt = (st_nxt == PS_MAIN);
   assign main_entry  = on_main_nxt & ~main_sel;

   bkup_sched #(
      .TEST_TICKS   (TEST_TICKS),
      .PULSE_TICKS  (PULSE_TICKS),
      .PERIOD_TICKS (PERIOD_TICKS)
   ) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_i),
      .on_main_nxt (on_main_nxt),
      .main_entry  (main_entry),
      .bat_good    (bat_good_i),
      .test_on     (test_on),
      .pulse_on    (pulse_on),
      .bat_res     (bat_res)
   );

   assign main_sel_o  = main_sel;
   assign bat_sel_o   = bat_sel;
   assign bat_on_o    = bat_sel;
   assign bat_ok_o    = bat_res & main_sel;
   assign test_load_o = test_on;

   if (TEST_PULSE_LOW) begin : g_pulse_low
      assign test_pulse_o = ~pulse_on;
   end else begin : g_pulse_high
      assign test_pulse_o = pulse_on;
   end

   // R6: the battery is only ever selected with the seal armed
   assert_seal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bat_sel |-> armed);
   // R11: no test load unless the main supply feeds the rail
   assert_load_main_R11: assert property (@(posedge clk) disable iff (!rst_n)
      test_load_o |-> main_sel_o);
   // R11: health flag forced low in backup
   assert_ok_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bat_on_o |-> !bat_ok_o);
   // R4: never both switches
   assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(main_sel_o && bat_sel_o));

endmodule

// File: tb/bkup_seq_bench.sv
module bkup_seq_bench;

   localparam int unsigned TW = 3;
   localparam int unsigned PW = 4;
   localparam int unsigned PER = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic vlow = 1'b1, vltb = 1'b1, vhys = 1'b0, bgood = 1'b1;
   logic reseal = 1'b0, voff = 1'b0;
   logic msel, bsel, bon, bok, tload, tpulse;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   bkup_seq #(.TEST_TICKS(TW), .PULSE_TICKS(PW), .PERIOD_TICKS(PER),
              .TEST_PULSE_LOW(1'b0)) u_bkup_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .vmain_low_i(vlow), .vmain_lt_bat_i(vltb), .vmain_gt_bat_hys_i(vhys),
      .bat_good_i(bgood), .reseal_i(reseal), .vmain_off_i(voff),
      .main_sel_o(msel), .bat_sel_o(bsel), .bat_on_o(bon), .bat_ok_o(bok),
      .test_load_o(tload), .test_pulse_o(tpulse));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic t);
      tick = t;
      @(posedge clk);
      #2;
      tick = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1);
   endtask

   task automatic sup_good();
      vlow = 1'b0; vltb = 1'b0; vhys = 1'b1;
   endtask

   task automatic sup_dead();
      vlow = 1'b1; vltb = 1'b1; vhys = 1'b0;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1", "main_sel", msel, 1'b0);
      chk("R1", "bat_sel", bsel, 1'b0);
      chk("R1", "bat_ok", bok, 1'b0);
      chk("R1", "test_load", tload, 1'b0);
      chk("R1", "test_pulse", tpulse, 1'b0);
      rst_n = 1'b1;
      // R6 battery alone never powers the rail
      run_ticks(3);
      chk("R6", "bat_sel before first supply", bsel, 1'b0);
      chk("R1", "main_sel idle", msel, 1'b0);
      // supply arrives
      sup_good();
      cyc(1'b0);
      chk("R1", "main_sel on supply up", msel, 1'b1);
      chk("R7", "test_load starts", tload, 1'b1);
      chk("R8", "pulse starts", tpulse, 1'b1);
      chk("R10", "bat_ok before first result", bok, 1'b0);
      cyc(1'b0);
      run_ticks(TW - 1);
      chk("R7", "load before last tick", tload, 1'b1);
      run_ticks(1);
      chk("R7", "load after window", tload, 1'b0);
      chk("R10", "bat_ok after pass", bok, 1'b1);
      chk("R8", "pulse still active", tpulse, 1'b1);
      run_ticks(PW - TW);
      chk("R8", "pulse ended", tpulse, 1'b0);
      run_ticks(PER - PW - 1);
      chk("R9", "no retest before period", tload, 1'b0);
      run_ticks(1);
      chk("R9", "retest at period", tload, 1'b1);
      chk("R9", "pulse at retest", tpulse, 1'b1);
      bgood = 1'b0;
      run_ticks(TW - 1);
      chk("R10", "result held mid window", bok, 1'b1);
      run_ticks(1);
      chk("R10", "fail latched", bok, 1'b0);
      bgood = 1'b1;
      run_ticks(1);
      chk("R10", "fail held after window", bok, 1'b0);
      // R2 below reset but above battery: stay on supply
      vlow = 1'b1; vltb = 1'b0; vhys = 1'b0;
      run_ticks(2);
      chk("R2", "stay main, above battery", msel, 1'b1);
      chk("R2", "no battery, above battery", bsel, 1'b0);
      // R2/R4 switch to battery through the gap
      vltb = 1'b1;
      cyc(1'b0);
      chk("R4", "gap main", msel, 1'b0);
      chk("R4", "gap bat", bsel, 1'b0);
      chk("R11", "gap bat_ok", bok, 1'b0);
      cyc(1'b0);
      chk("R4", "gap waits for tick", bsel, 1'b0);
      cyc(1'b1);
      chk("R2", "battery selected", bsel, 1'b1);
      chk("R5", "bat_on follows", bon, 1'b1);
      chk("R11", "bat_ok low in backup", bok, 1'b0);
      run_ticks(PER + 2);
      chk("R11", "no test in backup", tload, 1'b0);
      chk("R11", "no pulse in backup", tpulse, 1'b0);
      // R3 recovery without hysteresis margin stays on battery
      vlow = 1'b0; vltb = 1'b0; vhys = 1'b0;
      run_ticks(2);
      chk("R3", "battery held without margin", bsel, 1'b1);
      vhys = 1'b1;
      cyc(1'b0);
      chk("R3", "gap back bat", bsel, 1'b0);
      chk("R5", "bat_on in gap", bon, 1'b0);
      chk("R4", "gap back main", msel, 1'b0);
      cyc(1'b1);
      chk("R3", "main restored", msel, 1'b1);
      chk("R7", "test on return", tload, 1'b1);
      run_ticks(TW);
      chk("R10", "pass after return", bok, 1'b1);
      // R2 gap aborted when conditions vanish
      sup_dead();
      cyc(1'b0);
      chk("R4", "gap entered", msel, 1'b0);
      sup_good();
      cyc(1'b1);
      chk("R2", "aborted gap returns main", msel, 1'b1);
      chk("R2", "aborted gap no battery", bsel, 1'b0);
      chk("R7", "test on aborted-gap return", tload, 1'b1);
      // R10 window cut short is not sampled
      bgood = 1'b0;
      run_ticks(1);
      sup_dead();
      cyc(1'b0);
      cyc(1'b1);
      chk("R2", "back on battery", bsel, 1'b1);
      sup_good();
      cyc(1'b0);
      cyc(1'b1);
      chk("R10", "cut window left result", bok, 1'b1);
      bgood = 1'b1;
      // R6 reseal ignored with supply on
      reseal = 1'b1;
      cyc(1'b1);
      chk("R6", "reseal ignored main", msel, 1'b1);
      reseal = 1'b0;
      sup_dead();
      cyc(1'b0);
      cyc(1'b1);
      chk("R2", "battery before reseal", bsel, 1'b1);
      voff = 1'b1; reseal = 1'b1;
      cyc(1'b0);
      chk("R6", "reseal drops battery", bsel, 1'b0);
      chk("R6", "reseal main off", msel, 1'b0);
      reseal = 1'b0;
      run_ticks(3);
      chk("R6", "sealed stays off", bsel, 1'b0);
      voff = 1'b0;
      sup_good();
      cyc(1'b0);
      chk("R1", "main after reseal", msel, 1'b1);
      chk("R7", "test after reseal", tload, 1'b1);
      summary();
   end

endmodule